// File: doc/BRIEF.md
# Graphics Mode Pixel Serializer

This block turns display bytes, fetched elsewhere from video memory, into a stream of palette-indexed colour codes. It produces one code per dot on each cycle where the pixel clock enable is high. The graphics-mode word `gm` selects the depth and the width of a pixel. When `gm[0]` is 1 the mode is two-colour, with one bit per pixel. When `gm[0]` is 0 the mode is four-colour, with a bit pair per pixel. The full-resolution two-colour mode gives 256 dots per line. Its four-colour sibling gives 128 pixels, each two dots wide, and a palette-set input picks one of two four-colour palettes.

A byte is captured on a load strobe and then consumed pixel by pixel, most significant bit or bit pair first. Dots outside the active line, dots in non-graphics mode and dots after the byte is used up all come out as a fixed black background code. Character generation, block semigraphics and video encoding are outside this block.

Top module: `gfx_pixel_serializer`

## Requirements
- R1: After reset `pix_color` is black (code 8) and the shifter holds no data, so dots stay black until the first load.
- R2: A `load` cycle captures `load_data` and restarts the byte at its first pixel. When `load` and `pix_ce` are high together, the load wins: no dot is emitted and `pix_color` holds its value.
- R3: In two-colour modes (`gm[0]`=1) each pixel is one bit, taken MSB first. A 1 gives the foreground code: green (0) when `pal_sel`=0, buff (4) when `pal_sel`=1. A 0 gives black (8).
- R4: In four-colour modes (`gm[0]`=0) each pixel is a bit pair, taken from the top pair down, and the code is {0, `pal_sel`, pair}. With `pal_sel`=0 the pairs 0..3 give green, yellow, blue, red (codes 0..3). With `pal_sel`=1 they give buff, cyan, magenta, orange (codes 4..7).
- R5: A pixel lasts 1 dot when `gm`=3'b111, 4 dots when `gm`=3'b000, and 2 dots in every other mode.
- R6: Once all eight bits of a byte are consumed, every dot is black until the next load.
- R7: A dot with `line_valid` low is black and consumes no pixel data.
- R8: A dot with `gfx_sel` low is black, but the pixel data still advances as if it were shown.
- R9: In a cycle with `pix_ce` low, `pix_color` and the pixel position both hold.
- R10: `pix_color` changes at the clock edge of a `pix_ce` cycle and shows the pixel that was current before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Dot clock enable |
| line_valid | input | 1 | Active part of the line |
| load | input | 1 | Capture `load_data` as the next byte |
| load_data | input | 8 | Display byte |
| gfx_sel | input | 1 | 1 = graphics, 0 = alphanumeric (background only) |
| gm | input | 3 | Graphics mode; bit 0 picks two-colour |
| pal_sel | input | 1 | Palette set select |
| pix_color | output | 4 | Colour code of the current dot |

## Verification
The hardest state to reach is a byte that is only partly consumed while the stimulus keeps interrupting it. In that state, blank dots, idle cycles and dots in alphanumeric mode fall between the steps of a multi-dot pixel. Each of these must be told apart from the others: a blank dot pauses consumption, an alphanumeric dot advances it, and an idle cycle holds everything. Random cycles mix these conditions at a high rate within each byte and sometimes change the mode mid-byte, so the hold and shift counters are reached in unusual phases. Directed sequences separately pin down the exact dot patterns for the widest, narrowest and four-dot pixel modes.

// File: rtl/gps_pkg.sv
package gps_pkg;
  localparam int COLOR_W = 4;
  localparam logic [COLOR_W-1:0] C_BLACK = 4'd8;
  localparam logic [COLOR_W-1:0] C_GREEN = 4'd0;
  localparam logic [COLOR_W-1:0] C_BUFF  = 4'd4;

  // Dots each pixel occupies for a graphics mode word
  function automatic logic [2:0] dots_per_pix(input logic [2:0] gm);
    case (gm)
      3'b111:  return 3'd1;
      3'b000:  return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  // Colour code for a pixel value
  function automatic logic [COLOR_W-1:0] color_of(input logic two_col,
                                                  input logic pal,
                                                  input logic [1:0] bits);
    if (two_col) return bits[1] ? (pal ? C_BUFF : C_GREEN) : C_BLACK;
    return {1'b0, pal, bits};
  endfunction
endpackage

// File: rtl/gps_shifter.sv
module gps_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              step,
  input  logic              two_col,
  input  logic [2:0]        hold_lim,
  output logic [1:0]        pix_bits,
  output logic              empty
);
  localparam int BW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bits_left;
  logic [2:0]        hold_cnt;
  logic [BW-1:0]     bpp;

  assign bpp      = two_col ? BW'(1) : BW'(2);
  assign pix_bits = sh[DATA_W-1 -: 2];
  assign empty    = (bits_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
      hold_cnt  <= '0;
    end else if (load) begin
      sh        <= data;
      bits_left <= BW'(DATA_W);
      hold_cnt  <= '0;
    end else if (step) begin
      if (hold_cnt + 3'd1 >= hold_lim) begin
        hold_cnt  <= '0;
        sh        <= two_col ? (sh << 1) : (sh << 2);
        bits_left <= (bits_left <= bpp) ? '0 : bits_left - bpp;
      end else begin
        hold_cnt <= hold_cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/gps_colormap.sv
module gps_colormap
  import gps_pkg::*;
(
  input  logic               two_col,
  input  logic               pal,
  input  logic               show,
  input  logic [1:0]         pix_bits,
  output logic [COLOR_W-1:0] code
);
  always_comb begin
    code = show ? color_of(two_col, pal, pix_bits) : C_BLACK;
  end
endmodule

// File: rtl/gfx_pixel_serializer.sv
module gfx_pixel_serializer
  import gps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              line_valid,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              gfx_sel,
  input  logic [2:0]        gm,
  input  logic              pal_sel,
  output logic [3:0]        pix_color
);
  logic       byte_empty;
  logic       dot_step;
  logic       dot_show;
  logic [1:0] pix_bits;
  logic [3:0] dot_code;
  logic       two_col;

  assign two_col  = gm[0];
  assign dot_step = pix_ce & line_valid & ~load & ~byte_empty;
  assign dot_show = gfx_sel & line_valid & ~byte_empty;

  gps_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .data     (load_data),
    .step     (dot_step),
    .two_col  (two_col),
    .hold_lim (dots_per_pix(gm)),
    .pix_bits (pix_bits),
    .empty    (byte_empty)
  );

  gps_colormap u_cmap (
    .two_col  (two_col),
    .pal      (pal_sel),
    .show     (dot_show),
    .pix_bits (pix_bits),
    .code     (dot_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                pix_color <= C_BLACK;
    else if (pix_ce && !load)  pix_color <= dot_code;
  end
endmodule

// File: rtl/gfx_pixel_serializer_chk.sv
module gfx_pixel_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_ce,
  input logic       line_valid,
  input logic       load,
  input logic       gfx_sel,
  input logic [2:0] gm,
  input logic       pal_sel,
  input logic [3:0] pix_color,
  input logic       dot_step,
  input logic       byte_empty
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_ce |=> $stable(pix_color)); // R9
  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> $stable(pix_color)); // R2
  AST_LINE_OFF_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !load && !line_valid) |=> pix_color == 4'd8); // R7
  AST_ALPHA_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !load && !gfx_sel) |=> pix_color == 4'd8); // R8
  AST_UNDERRUN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ce && !load && byte_empty) |=> pix_color == 4'd8); // R6
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_empty && !load) |=> byte_empty); // R6
  AST_FOURCOL_PAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_step && gfx_sel && !gm[0]) |=> pix_color[3:2] == {1'b0, $past(pal_sel)}); // R4
  AST_TWOCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_step && gfx_sel && gm[0]) |=>
      (pix_color == 4'd8 || pix_color == {1'b0, $past(pal_sel), 2'b00})); // R3
endmodule

bind gfx_pixel_serializer gfx_pixel_serializer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_ce     (pix_ce),
  .line_valid (line_valid),
  .load       (load),
  .gfx_sel    (gfx_sel),
  .gm         (gm),
  .pal_sel    (pal_sel),
  .pix_color  (pix_color),
  .dot_step   (dot_step),
  .byte_empty (byte_empty)
);

// File: tb/gfx_pixel_serializer_tb.sv
`timescale 1ns/1ps
module gfx_pixel_serializer_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       pix_ce = 0, line_valid = 0, load = 0, gfx_sel = 0, pal_sel = 0;
  logic [7:0] load_data = 0;
  logic [2:0] gm = 0;
  logic [3:0] pix_color;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_sh;
  int         m_bits, m_hold;
  logic [3:0] m_out;

  always #2 clk = ~clk;

  gfx_pixel_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .line_valid(line_valid),
    .load(load), .load_data(load_data), .gfx_sel(gfx_sel), .gm(gm),
    .pal_sel(pal_sel), .pix_color(pix_color)
  );

  function automatic int width_of(input logic [2:0] mode);
    if (mode == 3'b111) return 1;
    if (mode == 3'b000) return 4;
    return 2;
  endfunction

  function automatic logic [3:0] exp_code(input logic [2:0] mode, input logic pal,
                                          input logic [7:0] sh);
    if (mode[0]) begin
      if (!sh[7]) return 4'd8;
      return pal ? 4'd4 : 4'd0;
    end
    return 4'(pal * 4 + sh[7:6]);
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_cmp++;
    if (pix_color !== exp) begin
      n_bad++;
      $display("FAIL %s: pix_color=%0d expected=%0d", tag, pix_color, exp);
    end
  endtask

  // one clock with given inputs; model update; check after the edge (R10)
  task automatic cyc(input logic ld, input logic [7:0] d, input logic ce,
                     input logic lv, input logic gs, input logic [2:0] mode,
                     input logic pal, input string tag);
    load = ld; load_data = d; pix_ce = ce; line_valid = lv;
    gfx_sel = gs; gm = mode; pal_sel = pal;
    if (ld) begin
      m_sh = d; m_bits = 8; m_hold = 0;
    end else if (ce) begin
      if (!lv || m_bits == 0) m_out = 4'd8;
      else begin
        m_out = gs ? exp_code(mode, pal, m_sh) : 4'd8;
        m_hold++;
        if (m_hold >= width_of(mode)) begin
          m_hold = 0;
          if (mode[0]) begin m_sh = m_sh << 1; m_bits = m_bits - 1; end
          else begin m_sh = m_sh << 2; m_bits = (m_bits <= 2) ? 0 : m_bits - 2; end
        end
      end
    end
    @(posedge clk); #1;
    check(tag, m_out);
    @(negedge clk);
  endtask

  task automatic dot(input logic [2:0] mode, input logic pal, input string tag);
    cyc(0, 8'h00, 1, 1, 1, mode, pal, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_sh = 0; m_bits = 0; m_hold = 0; m_out = 4'd8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 reset value", 4'd8);
    dot(3'b111, 0, "R1 empty after reset");
    dot(3'b110, 1, "R1 empty after reset");

    // R3/R5 full-width two-colour, pattern 1010_0101, palette 0 then 1
    cyc(1, 8'hA5, 0, 1, 1, 3'b111, 0, "R2 load");
    for (int i = 0; i < 8; i++) dot(3'b111, 0, "R3 R5 two-colour 1-dot");
    dot(3'b111, 0, "R6 underrun");
    cyc(1, 8'hC3, 0, 1, 1, 3'b111, 1, "R2 load");
    for (int i = 0; i < 8; i++) dot(3'b111, 1, "R3 buff foreground");

    // R4 four-colour 2-dot, pairs 0,1,2,3 palette 1
    cyc(1, 8'h1B, 0, 1, 1, 3'b110, 1, "R2 load");
    for (int i = 0; i < 8; i++) dot(3'b110, 1, "R4 R5 four-colour 2-dot");
    dot(3'b110, 1, "R6 underrun");

    // R5 four-dot pixels, palette 0, pairs 3,2,1,0
    cyc(1, 8'hE4, 0, 1, 1, 3'b000, 0, "R2 load");
    for (int i = 0; i < 16; i++) dot(3'b000, 0, "R4 R5 four-dot");

    // R5 two-colour 2-dot
    cyc(1, 8'h96, 0, 1, 1, 3'b011, 0, "R2 load");
    for (int i = 0; i < 16; i++) dot(3'b011, 0, "R3 R5 two-colour 2-dot");

    // R7 blank pauses, R8 alpha advances, R9 idle holds, R2 load+ce
    cyc(1, 8'h6C, 0, 1, 1, 3'b110, 0, "R2 load");
    dot(3'b110, 0, "R4 first dot");
    cyc(0, 0, 1, 0, 1, 3'b110, 0, "R7 blank dot black");
    cyc(0, 0, 0, 1, 1, 3'b110, 0, "R9 idle holds");
    cyc(0, 0, 1, 1, 0, 3'b110, 0, "R8 alpha dot black");
    dot(3'b110, 0, "R8 data advanced");
    cyc(1, 8'hFF, 1, 1, 1, 3'b110, 0, "R2 load wins over dot");
    dot(3'b110, 0, "R2 restarted byte");

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic [2:0] mode;
      logic       pal;
      mode = 3'($urandom_range(0, 7));
      pal  = 1'($urandom_range(0, 1));
      cyc(1, 8'($urandom), 1'($urandom_range(0, 3) == 0), 1, 1, mode, pal, "R2 random load");
      for (int k = 0; k < int'($urandom_range(4, 24)); k++) begin
        logic ce, lv, gs;
        ce = ($urandom_range(0, 9) < 7);
        lv = ($urandom_range(0, 9) < 8);
        gs = ($urandom_range(0, 9) < 8);
        if ($urandom_range(0, 49) == 0) mode = 3'($urandom_range(0, 7));
        cyc(0, 0, ce, lv, gs, mode, pal,
            !ce ? "R9 random idle" : !lv ? "R7 random blank" :
            !gs ? "R8 random alpha" : mode[0] ? "R3 random" : "R4 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule